// File: doc/BRIEF.md
# Integer Execute Unit with Iterative Divider

This block is the integer execute stage of a 32-bit load/store processor. It takes one instruction word together with the two source operand values already read from the register file. It returns the value for the destination register, the destination index, a write enable and an illegal-instruction trap flag. Register forms take the second operand from the register file. Immediate forms build it from the low 16 bits of the instruction. Arithmetic immediates are sign-extended. Logical immediates and the multiply immediate are zero-extended.

Add, subtract, the logical operations, multiply (low half of the product), the four shift and rotate kinds and the high-immediate load all finish in the issue cycle. Signed and unsigned division use a restoring divider that produces one quotient bit per cycle. It is controlled by a three-state machine: `DV_IDLE` waits for a start. `DV_RUN` runs one iteration per cycle and moves to `DV_DONE` after the last of `DATA_W` iterations. `DV_DONE` presents the quotient for one cycle and returns to `DV_IDLE`. The parameter `ITER_DIV` = 0 replaces the machine with a single-cycle divider, and `busy_o` then stays low. A zero divisor traps in the issue cycle and never starts the divider.

Top module: `alu_exec`

## Requirements
- R1: Register forms have bits 31:30 = 3 and bits 29:26 = 8. Bits 3:0 select the operation: 0 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 multiply (low 32 bits), 9 signed divide, 10 unsigned divide. Bits 10:4 must be zero, otherwise the instruction traps.
- R2: Immediate forms have bits 31:30 = 2 and take the immediate from bits 15:0. For add (bits 29:26 = 5) and subtract (bits 29:26 = 7) the immediate is sign-extended.
- R3: AND (bits 29:26 = 8), OR (9), XOR (10) and multiply (11) immediates are zero-extended.
- R4: A register shift has bits 3:0 = 8 and takes its amount from rB bits 4:0. Bits 7:5 pick the kind: 0 shift left, 1 logical shift right, 2 arithmetic shift right, 4 rotate right. Any other kind, or a nonzero value in bits 10:8 or bit 4, traps.
- R5: An immediate shift has bits 31:30 = 2 and bits 29:26 = 13. The kind is in bits 7:5, coded as in R4, and the amount is in bits 4:0. If bits 15:8 are nonzero the instruction traps.
- R6: Bits 31:30 = 0 with bits 29:26 = 6 write the 16-bit immediate shifted left by 16.
- R7: Every non-trapping result asserts `wr_en_o`, and `rd_o` carries the instruction's bits 25:21. Non-divide results appear in the issue cycle.
- R8: Every encoding not listed in R1 to R6 raises `trap_o` with `wr_en_o` low and `result_o` zero.
- R9: A divide with a zero divisor raises `trap_o` in the issue cycle, writes nothing and leaves `busy_o` low.
- R10: Signed division truncates toward zero. The most-negative value divided by -1 gives the most-negative value and does not trap. Unsigned division treats both operands as unsigned.
- R11: With the iterative divider, a divide issued in cycle 0 produces its result, with its own `rd_o`, in cycle `DATA_W`+1. `busy_o` is high from cycle 1 through that result cycle, and issues presented while `busy_o` is high are ignored.
- R12: During and after reset, `out_valid_o`, `wr_en_o`, `trap_o` and `busy_o` are low while nothing is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction presented this cycle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | DATA_W | First source operand value |
| opb_i | input | DATA_W | Second source operand value |
| out_valid_o | output | 1 | Result, trap or write valid this cycle |
| result_o | output | DATA_W | Destination value (zero on trap) |
| rd_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Destination write enable |
| trap_o | output | 1 | Illegal-instruction trap |
| busy_o | output | 1 | Iterative divide in progress |

## Verification
The assertions check on every cycle that a trap never comes with a write and always forces a zero result. They also check that every other valid result writes, that the destination index follows the issued word outside a divide, that the busy machine stays silent until its single result cycle, and that unknown class codes, logical immediates and zero divisors are handled as specified. Whether the arithmetic is right for each operation, how the shift and rotate amounts behave at 0 and 31, the signed quotient rounding and the overflow case, the exact divide latency and the rejection of an instruction held high across a busy divide can only be shown by the bench. It compares those against its own reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_MUL,
        OP_SLL,
        OP_SRL,
        OP_SRA,
        OP_ROR,
        OP_PASSB,
        OP_DIVS,
        OP_DIVU,
        OP_NONE
    } op_e;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_DONE
    } dv_state_e;

    // major class field, bits 31:30
    localparam logic [1:0] CLS_CTL = 2'd0;
    localparam logic [1:0] CLS_IMM = 2'd2;
    localparam logic [1:0] CLS_REG = 2'd3;

    // sub-class field, bits 29:26
    localparam logic [3:0] SUB_HIMM   = 4'd6;
    localparam logic [3:0] SUB_REGALU = 4'd8;
    localparam logic [3:0] SUB_ADDI   = 4'd5;
    localparam logic [3:0] SUB_SUBI   = 4'd7;
    localparam logic [3:0] SUB_ANDI   = 4'd8;
    localparam logic [3:0] SUB_ORI    = 4'd9;
    localparam logic [3:0] SUB_XORI   = 4'd10;
    localparam logic [3:0] SUB_MULI   = 4'd11;
    localparam logic [3:0] SUB_SHI    = 4'd13;

    // register-form function code, bits 3:0
    localparam logic [3:0] FN_ADD   = 4'd0;
    localparam logic [3:0] FN_SUB   = 4'd2;
    localparam logic [3:0] FN_AND   = 4'd3;
    localparam logic [3:0] FN_OR    = 4'd4;
    localparam logic [3:0] FN_XOR   = 4'd5;
    localparam logic [3:0] FN_MUL   = 4'd6;
    localparam logic [3:0] FN_SHIFT = 4'd8;
    localparam logic [3:0] FN_DIVS  = 4'd9;
    localparam logic [3:0] FN_DIVU  = 4'd10;

    function automatic op_e shift_kind(input logic [2:0] k);
        case (k)
            3'd0:    return OP_SLL;
            3'd1:    return OP_SRL;
            3'd2:    return OP_SRA;
            3'd4:    return OP_ROR;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] opb_i,
    output op_e               op_o,
    output logic [DATA_W-1:0] opnd_b_o
);
    logic [1:0]        cls;
    logic [3:0]        sub;
    logic [15:0]       imm;
    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] imm_zx;
    logic [DATA_W-1:0] imm_hi;
    logic [DATA_W-1:0] amt_reg;
    logic [DATA_W-1:0] amt_imm;
    logic              unused_fields;

    assign cls           = insn_i[31:30];
    assign sub           = insn_i[29:26];
    assign imm           = insn_i[15:0];
    assign unused_fields = ^insn_i[25:16];

    always_comb begin
        imm_sx       = {{(DATA_W-16){imm[15]}}, imm};
        imm_zx       = {{(DATA_W-16){1'b0}}, imm};
        imm_hi       = '0;
        imm_hi[31:0] = {imm, 16'h0000};
        amt_reg      = '0;
        amt_reg[4:0] = opb_i[4:0];
        amt_imm      = '0;
        amt_imm[4:0] = insn_i[4:0];
    end

    always_comb begin
        op_o     = OP_NONE;
        opnd_b_o = opb_i;
        unique case (cls)
            CLS_REG: begin
                if (sub == SUB_REGALU) begin
                    if (insn_i[3:0] == FN_SHIFT) begin
                        opnd_b_o = amt_reg;
                        if (insn_i[10:8] == 3'd0 && !insn_i[4])
                            op_o = shift_kind(insn_i[7:5]);
                    end else if (insn_i[10:4] == 7'd0) begin
                        case (insn_i[3:0])
                            FN_ADD:  op_o = OP_ADD;
                            FN_SUB:  op_o = OP_SUB;
                            FN_AND:  op_o = OP_AND;
                            FN_OR:   op_o = OP_OR;
                            FN_XOR:  op_o = OP_XOR;
                            FN_MUL:  op_o = OP_MUL;
                            FN_DIVS: op_o = OP_DIVS;
                            FN_DIVU: op_o = OP_DIVU;
                            default: op_o = OP_NONE;
                        endcase
                    end
                end
            end
            CLS_IMM: begin
                case (sub)
                    SUB_ADDI: begin op_o = OP_ADD; opnd_b_o = imm_sx; end
                    SUB_SUBI: begin op_o = OP_SUB; opnd_b_o = imm_sx; end
                    SUB_ANDI: begin op_o = OP_AND; opnd_b_o = imm_zx; end
                    SUB_ORI:  begin op_o = OP_OR;  opnd_b_o = imm_zx; end
                    SUB_XORI: begin op_o = OP_XOR; opnd_b_o = imm_zx; end
                    SUB_MULI: begin op_o = OP_MUL; opnd_b_o = imm_zx; end
                    SUB_SHI: begin
                        opnd_b_o = amt_imm;
                        if (insn_i[15:8] == 8'd0)
                            op_o = shift_kind(insn_i[7:5]);
                    end
                    default: op_o = OP_NONE;
                endcase
            end
            CLS_CTL: begin
                if (sub == SUB_HIMM) begin
                    op_o     = OP_PASSB;
                    opnd_b_o = imm_hi;
                end
            end
            default: op_o = OP_NONE;
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     amt;
    logic [2*DATA_W-1:0] doubled;
    logic [DATA_W-1:0]   product;

    assign amt     = b_i[SH_W-1:0];
    assign doubled = {a_i, a_i} >> amt;
    assign product = a_i * b_i;

    always_comb begin
        case (op_i)
            OP_ADD:   res_o = a_i + b_i;
            OP_SUB:   res_o = a_i - b_i;
            OP_AND:   res_o = a_i & b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_XOR:   res_o = a_i ^ b_i;
            OP_MUL:   res_o = product;
            OP_SLL:   res_o = a_i << amt;
            OP_SRL:   res_o = a_i >> amt;
            OP_SRA:   res_o = $unsigned($signed(a_i) >>> amt);
            OP_ROR:   res_o = doubled[DATA_W-1:0];
            OP_PASSB: res_o = b_i;
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_divider.sv
module alu_divider
    import alu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit ITER_DIV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signed_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quot_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    // magnitudes and the sign of the quotient; MIN maps to itself,
    // which is exactly its unsigned magnitude
    logic [DATA_W-1:0] mag_n;
    logic [DATA_W-1:0] mag_d;
    logic              neg_q;

    assign neg_q = signed_i & (dividend_i[DATA_W-1] ^ divisor_i[DATA_W-1]);
    assign mag_n = (signed_i && dividend_i[DATA_W-1]) ? -dividend_i : dividend_i;
    assign mag_d = (signed_i && divisor_i[DATA_W-1])  ? -divisor_i  : divisor_i;

    generate
        if (ITER_DIV) begin : g_iter
            dv_state_e         state_q;
            dv_state_e         state_d;
            logic [CNT_W-1:0]  cnt_q;
            logic [DATA_W:0]   rem_q;
            logic [DATA_W-1:0] quo_q;
            logic [DATA_W-1:0] den_q;
            logic              neg_qq;
            logic [DATA_W:0]   trial;
            logic              fits;

            assign trial = {rem_q[DATA_W-1:0], quo_q[DATA_W-1]};
            assign fits  = trial >= {1'b0, den_q};

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= DV_IDLE;
                else        state_q <= state_d;
            end

            // transitions
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    DV_IDLE: if (start_i) state_d = DV_RUN;
                    DV_RUN:  if (cnt_q == LAST) state_d = DV_DONE;
                    DV_DONE: state_d = DV_IDLE;
                    default: state_d = DV_IDLE;
                endcase
            end

            // iteration datapath
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q  <= '0;
                    rem_q  <= '0;
                    quo_q  <= '0;
                    den_q  <= '0;
                    neg_qq <= 1'b0;
                end else if (state_q == DV_IDLE && start_i) begin
                    cnt_q  <= '0;
                    rem_q  <= '0;
                    quo_q  <= mag_n;
                    den_q  <= mag_d;
                    neg_qq <= neg_q;
                end else if (state_q == DV_RUN) begin
                    cnt_q <= cnt_q + 1'b1;
                    rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
                    quo_q <= {quo_q[DATA_W-2:0], fits};
                end
            end

            // outputs
            always_comb begin
                busy_o = (state_q != DV_IDLE);
                done_o = (state_q == DV_DONE);
                quot_o = neg_qq ? -quo_q : quo_q;
            end
        end else begin : g_comb
            logic [DATA_W-1:0] raw_q;
            logic              unused_seq;

            assign unused_seq = clk ^ rst_n ^ start_i;
            assign raw_q      = (mag_d == '0) ? '0 : (mag_n / mag_d);

            always_comb begin
                busy_o = 1'b0;
                done_o = 1'b0;
                quot_o = neg_q ? -raw_q : raw_q;
            end
        end
    endgenerate

endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit ITER_DIV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [4:0]        rd_o,
    output logic              wr_en_o,
    output logic              trap_o,
    output logic              busy_o
);
    op_e               op;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] div_q;
    logic              div_busy;
    logic              div_done;
    logic              is_div;
    logic              div_zero;
    logic              trap_now;
    logic              accept;
    logic              div_start;
    logic [4:0]        rd_q;

    alu_decode #(.DATA_W(DATA_W)) u_dec (
        .insn_i   (insn_i),
        .opb_i    (opb_i),
        .op_o     (op),
        .opnd_b_o (opnd_b)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op_i  (op),
        .a_i   (opa_i),
        .b_i   (opnd_b),
        .res_o (logic_res)
    );

    assign is_div    = (op == OP_DIVS) || (op == OP_DIVU);
    assign div_zero  = is_div && (opnd_b == '0);
    assign trap_now  = (op == OP_NONE) || div_zero;
    assign accept    = issue_i && !div_busy;
    assign div_start = ITER_DIV && accept && is_div && !div_zero;

    alu_divider #(.DATA_W(DATA_W), .ITER_DIV(ITER_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .signed_i   (op == OP_DIVS),
        .dividend_i (opa_i),
        .divisor_i  (opnd_b),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quot_o     (div_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_q <= '0;
        else if (div_start) rd_q <= insn_i[25:21];
    end

    always_comb begin
        out_valid_o = 1'b0;
        result_o    = '0;
        rd_o        = '0;
        wr_en_o     = 1'b0;
        trap_o      = 1'b0;
        if (div_done) begin
            out_valid_o = 1'b1;
            result_o    = div_q;
            rd_o        = rd_q;
            wr_en_o     = 1'b1;
        end else if (accept && !div_start) begin
            out_valid_o = 1'b1;
            rd_o        = insn_i[25:21];
            trap_o      = trap_now;
            wr_en_o     = !trap_now;
            if (!trap_now) result_o = is_div ? div_q : logic_res;
        end
    end

    assign busy_o = div_busy;

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [31:0]       insn_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic [4:0]        rd_o,
    input logic              wr_en_o,
    input logic              trap_o,
    input logic              busy_o
);
    a_r8_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && trap_o |-> !wr_en_o && result_o == '0);

    a_r7_write_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> out_valid_o);

    a_r7_clean_result_writes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !trap_o |-> wr_en_o);

    a_r7_rd_from_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !busy_o |-> rd_o == insn_i[25:21]);

    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && busy_o |=> !busy_o);

    a_r11_silent_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !out_valid_o |-> !wr_en_o && !trap_o);

    a_r8_class1_traps: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !busy_o && insn_i[31:30] == 2'b01 |-> out_valid_o && trap_o);

    a_r3_and_imm_zext: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !busy_o && insn_i[31:26] == 6'b10_1000
        |-> result_o == (opa_i & {{(DATA_W-16){1'b0}}, insn_i[15:0]}));

    a_r9_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && !busy_o && insn_i[31:26] == 6'b11_1000 && insn_i[10:0] == 11'd9
        && opb_i == '0 |-> trap_o && !wr_en_o);

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i && !busy_o |-> !out_valid_o && !wr_en_o && !trap_o);

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .insn_i      (insn_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o),
    .rd_o        (rd_o),
    .wr_en_o     (wr_en_o),
    .trap_o      (trap_o),
    .busy_o      (busy_o)
);

// File: tb/alu_exec_tb.sv
`timescale 1ns/1ps
module alu_exec_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic [31:0]   insn_i = '0;
    logic [W-1:0]  opa_i = '0;
    logic [W-1:0]  opb_i = '0;
    logic          out_valid_o;
    logic [W-1:0]  result_o;
    logic [4:0]    rd_o;
    logic          wr_en_o;
    logic          trap_o;
    logic          busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    alu_exec #(.DATA_W(W), .ITER_DIV(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
        .opa_i(opa_i), .opb_i(opb_i), .out_valid_o(out_valid_o),
        .result_o(result_o), .rd_o(rd_o), .wr_en_o(wr_en_o),
        .trap_o(trap_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // encoders
    function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [3:0] fn, input logic [6:0] mid);
        return {2'b11, 4'd8, rd, 5'd1, 5'd2, mid, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [3:0] sub, input logic [4:0] rd, input logic [15:0] imm);
        return {2'b10, sub, rd, 5'd3, imm};
    endfunction

    // reference model from the requirements
    function automatic void model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic t, output logic slow);
        logic [1:0]  cls = w[31:30];
        logic [3:0]  sub = w[29:26];
        logic [31:0] sx  = {{16{w[15]}}, w[15:0]};
        logic [31:0] zx  = {16'h0, w[15:0]};
        int          s;
        r = '0; t = 1'b0; slow = 1'b0;
        if (cls == 2'd3 && sub == 4'd8) begin
            if (w[3:0] == 4'd8) begin
                s = int'(b[4:0]);
                if (w[10:8] != 0 || w[4]) t = 1'b1;
                else case (w[7:5])
                    3'd0: r = a << s;
                    3'd1: r = a >> s;
                    3'd2: r = $unsigned($signed(a) >>> s);
                    3'd4: r = (a >> s) | (a << (32 - s));
                    default: t = 1'b1;
                endcase
            end else if (w[10:4] != 0) t = 1'b1;
            else case (w[3:0])
                4'd0: r = a + b;
                4'd2: r = a - b;
                4'd3: r = a & b;
                4'd4: r = a | b;
                4'd5: r = a ^ b;
                4'd6: r = a * b;
                4'd9: begin
                    if (b == 0) t = 1'b1;
                    else begin
                        slow = 1'b1;
                        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) r = a;
                        else r = $unsigned($signed(a) / $signed(b));
                    end
                end
                4'd10: begin
                    if (b == 0) t = 1'b1;
                    else begin slow = 1'b1; r = a / b; end
                end
                default: t = 1'b1;
            endcase
        end else if (cls == 2'd2) begin
            case (sub)
                4'd5:  r = a + sx;
                4'd7:  r = a - sx;
                4'd8:  r = a & zx;
                4'd9:  r = a | zx;
                4'd10: r = a ^ zx;
                4'd11: r = a * zx;
                4'd13: begin
                    s = int'(w[4:0]);
                    if (w[15:8] != 0) t = 1'b1;
                    else case (w[7:5])
                        3'd0: r = a << s;
                        3'd1: r = a >> s;
                        3'd2: r = $unsigned($signed(a) >>> s);
                        3'd4: r = (a >> s) | (a << (32 - s));
                        default: t = 1'b1;
                    endcase
                end
                default: t = 1'b1;
            endcase
        end else if (cls == 2'd0 && sub == 4'd6) begin
            r = {w[15:0], 16'h0};
        end else t = 1'b1;
        if (t) begin r = '0; slow = 1'b0; end
    endfunction

    // issue one op; interfere=1 holds another issue high during a divide
    task automatic run_op(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                          input string req, input bit interfere);
        logic [31:0] er;
        logic        et;
        logic        es;
        int          lat;
        model(w, a, b, er, et, es);
        @(negedge clk);
        issue_i = 1'b1; insn_i = w; opa_i = a; opb_i = b;
        #2;
        if (!es) begin
            check(out_valid_o == 1'b1, {req, " valid"}, 32'(out_valid_o), 32'd1);
            check(trap_o == et, {req, " trap"}, 32'(trap_o), 32'(et));
            check(wr_en_o == !et, {req, " wr_en"}, 32'(wr_en_o), 32'(!et));
            check(result_o == er, {req, " result"}, result_o, er);
            check(rd_o == w[25:21], {req, " rd"}, 32'(rd_o), 32'(w[25:21]));
            @(negedge clk);
            issue_i = 1'b0;
        end else begin
            check(out_valid_o == 1'b0, {req, " R11 no result at issue"}, 32'(out_valid_o), 32'd0);
            @(negedge clk);
            if (interfere) begin
                insn_i = enc_i(4'd5, 5'd30, 16'h0001); opa_i = 32'd41;
            end else issue_i = 1'b0;
            lat = 0;
            for (int k = 1; k <= W + 8; k++) begin
                #2;
                if (k == 1)
                    check(busy_o == 1'b1, {req, " R11 busy"}, 32'(busy_o), 32'd1);
                if (out_valid_o && lat == 0) begin
                    lat = k;
                    check(result_o == er, {req, " quotient"}, result_o, er);
                    check(rd_o == w[25:21], {req, " R11 rd"}, 32'(rd_o), 32'(w[25:21]));
                    check(wr_en_o && !trap_o, {req, " R11 write"}, 32'({wr_en_o, trap_o}), 32'd2);
                end
                @(negedge clk);
                if (lat != 0) break;
            end
            check(lat == W + 1, {req, " R11 latency"}, 32'(lat), 32'(W + 1));
            if (interfere) begin
                #2;
                check(out_valid_o && result_o == 32'd42 && rd_o == 5'd30,
                      "R11 held issue accepted after done", result_o, 32'd42);
                @(negedge clk);
                issue_i = 1'b0;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] w;
        logic [31:0] a;
        logic [31:0] b;
        int          form;
        logic [3:0]  fns [8] = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10};
        logic [3:0]  subs[6] = '{4'd5, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11};
        void'($urandom(32'd2718));

        // R12 reset state
        #3;
        check(!out_valid_o && !wr_en_o && !trap_o && !busy_o, "R12 in reset",
              32'({out_valid_o, wr_en_o, trap_o, busy_o}), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(!out_valid_o && !wr_en_o && !trap_o && !busy_o, "R12 after reset",
              32'({out_valid_o, wr_en_o, trap_o, busy_o}), 32'd0);

        // directed corners
        run_op(enc_r(5'd4, 4'd0, 7'd0), 32'd5, 32'hFFFF_FFFE, "R1 add", 1'b0);
        run_op(enc_r(5'd4, 4'd6, 7'd0), 32'h0001_0003, 32'h0002_0005, "R1 mul low", 1'b0);
        run_op(enc_r(5'd4, 4'd0, 7'h10), 32'd5, 32'd6, "R1 reserved bits trap", 1'b0);
        run_op(enc_i(4'd5, 5'd7, 16'hFFFF), 32'd10, 32'd0, "R2 addi sext", 1'b0);
        run_op(enc_i(4'd7, 5'd7, 16'h8000), 32'd0, 32'd0, "R2 subi sext", 1'b0);
        run_op(enc_i(4'd8, 5'd7, 16'hF0F0), 32'hFFFF_FFFF, 32'd0, "R3 andi zext", 1'b0);
        run_op(enc_i(4'd11, 5'd7, 16'hFFFF), 32'd2, 32'd0, "R3 muli zext", 1'b0);
        run_op(enc_r(5'd9, 4'd8, {3'd0, 3'd4, 1'b0}), 32'h8000_0001, 32'd0, "R4 ror by 0", 1'b0);
        run_op(enc_r(5'd9, 4'd8, {3'd0, 3'd4, 1'b0}), 32'h8000_0001, 32'hFFFF_FFE1, "R4 ror amt from low bits", 1'b0);
        run_op(enc_r(5'd9, 4'd8, {3'd0, 3'd2, 1'b0}), 32'h8000_0000, 32'd31, "R4 sra", 1'b0);
        run_op(enc_r(5'd9, 4'd8, {3'd0, 3'd3, 1'b0}), 32'h1, 32'd1, "R4 kind 3 trap", 1'b0);
        run_op(enc_i(4'd13, 5'd2, {8'h00, 3'd0, 5'd31}), 32'h3, 32'd0, "R5 slli 31", 1'b0);
        run_op(enc_i(4'd13, 5'd2, {8'h01, 3'd1, 5'd4}), 32'hF0, 32'd0, "R5 reserved trap", 1'b0);
        run_op({2'b00, 4'd6, 5'd12, 5'd0, 16'hBEEF}, 32'h1234, 32'h5678, "R6 high imm", 1'b0);
        run_op({2'b01, 4'd0, 5'd12, 21'h0}, 32'd1, 32'd1, "R8 class 1", 1'b0);
        run_op(enc_i(4'd2, 5'd3, 16'h0), 32'd1, 32'd1, "R8 unknown imm sub", 1'b0);
        run_op(enc_r(5'd6, 4'd9, 7'd0), 32'd100, 32'd0, "R9 signed div by zero", 1'b0);
        #2 check(busy_o == 1'b0, "R9 no busy after zero divisor", 32'(busy_o), 32'd0);
        run_op(enc_r(5'd6, 4'd9, 7'd0), 32'hFFFF_FFF9, 32'd2, "R10 -7/2", 1'b0);
        run_op(enc_r(5'd6, 4'd9, 7'd0), 32'h8000_0000, 32'hFFFF_FFFF, "R10 min/-1", 1'b0);
        run_op(enc_r(5'd6, 4'd10, 7'd0), 32'hFFFF_FFFF, 32'd3, "R10 unsigned", 1'b0);
        run_op(enc_r(5'd11, 4'd10, 7'd0), 32'd1000, 32'd7, "R11 busy ignores issue", 1'b1);

        // constrained random, R1 R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 300; i++) begin
            form = $urandom_range(0, 5);
            a = $urandom();
            b = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom();
            case (form)
                0: w = enc_r(5'($urandom()), fns[$urandom_range(0, 7)], 7'd0);
                1: w = enc_r(5'($urandom()), 4'd8, {3'd0, 3'($urandom()), 1'b0});
                2: w = enc_i(subs[$urandom_range(0, 5)], 5'($urandom()), 16'($urandom()));
                3: w = enc_i(4'd13, 5'($urandom()), {8'h0, 8'($urandom())});
                4: w = {2'b00, 4'd6, 5'($urandom()), 5'd0, 16'($urandom())};
                default: w = $urandom();
            endcase
            run_op(w, a, b, "R7 random", 1'b0);
        end

        finish_run();
    end
endmodule